// File: doc/BRIEF.md
# Register-Register Integer ALU

This block is the integer execution unit of a small load/store RISC core. Each operation takes two register operands, plus a shift distance that comes from a field of the instruction, and returns one result word. It also raises a flag when that result is zero, so a branch on equal or not-equal can subtract its two operands and test the flag. The operation select arrives already decoded as a 4-bit code. Register access and overflow traps are handled elsewhere.

The arithmetic operations are wrapping add and subtract. The bitwise operations are AND, OR, XOR and NOR, and NOR against a zero operand acts as NOT. There are three shifts of the second operand: left logical, right logical and right arithmetic. There are also two compares, one signed and one unsigned, each of which returns 0 or 1 in the result word.

The parameter `REG_OUT` selects how the result leaves the block. With `REG_OUT = 0` the path is purely combinational. With `REG_OUT = 1` the result and the flag pass through one register stage.

Top module: `int_alu`

## Requirements
- R1: Code 0x0 (add) returns a + b modulo 2^32, with no overflow indication.
- R2: Code 0x1 (subtract) returns a - b modulo 2^32.
- R3: Codes 0x2, 0x3 and 0x4 return the bitwise AND, OR and XOR of a and b.
- R4: Code 0x5 (NOR) returns ~(a | b). With b = 0 the result is ~a.
- R5: Code 0x6 shifts b left by shamt (0 to 31) and fills the vacated low bits with 0. A shamt of 0 returns b unchanged.
- R6: Code 0x7 shifts b right by shamt and fills the vacated high bits with 0.
- R7: Code 0x8 shifts b right by shamt and fills the vacated high bits with copies of b[31].
- R8: Code 0x9 returns 1 when a < b as two's-complement numbers and 0 otherwise. Bits 31:1 of the result are always 0.
- R9: Code 0xA returns 1 when a < b as unsigned numbers and 0 otherwise. For a = 0xFFFFFFFF and b = 1, code 0x9 returns 1 and code 0xA returns 0.
- R10: Codes 0xB to 0xF return 0.
- R11: zero_flag is 1 exactly when result equals 0.
- R12: With REG_OUT = 1, result and zero_flag reflect the inputs present at the previous rising clock edge. While rst_n is low, result is 0 and zero_flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_sel | input | 4 | Decoded operation code |
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand, which is also the value that is shifted |
| shamt | input | SHW | Shift distance from the instruction |
| result | output | WIDTH | Operation result |
| zero_flag | output | 1 | High when result is zero |

## Verification
The bench builds two copies of the block at WIDTH = 32. The copy with REG_OUT = 1 exercises the one-cycle latency and the reset value of the output stage. The copy with REG_OUT = 0 checks the combinational result in the same cycle as its inputs. Directed vectors cover the sign boundaries 0x80000000 and 0x7FFFFFFF, the signed and unsigned compare of 0xFFFFFFFF against 1, the shift distances 0 and 31, NOR with zero, and every unused code. Random operands then run across all sixteen codes.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [SHW-1:0]   shamt,
  output logic [WIDTH-1:0] result,
  output logic             zero_flag
);

  localparam logic [3:0] OP_ADD  = 4'h0;
  localparam logic [3:0] OP_SUB  = 4'h1;
  localparam logic [3:0] OP_AND  = 4'h2;
  localparam logic [3:0] OP_OR   = 4'h3;
  localparam logic [3:0] OP_XOR  = 4'h4;
  localparam logic [3:0] OP_NOR  = 4'h5;
  localparam logic [3:0] OP_SLL  = 4'h6;
  localparam logic [3:0] OP_SRL  = 4'h7;
  localparam logic [3:0] OP_SRA  = 4'h8;
  localparam logic [3:0] OP_SLT  = 4'h9;
  localparam logic [3:0] OP_SLTU = 4'hA;

  logic [WIDTH-1:0] res_c;
  logic             lt_s, lt_u;

  assign lt_s = $signed(opnd_a) < $signed(opnd_b);
  assign lt_u = opnd_a < opnd_b;

  always_comb begin
    case (op_sel)
      OP_ADD:  res_c = opnd_a + opnd_b;
      OP_SUB:  res_c = opnd_a - opnd_b;
      OP_AND:  res_c = opnd_a & opnd_b;
      OP_OR:   res_c = opnd_a | opnd_b;
      OP_XOR:  res_c = opnd_a ^ opnd_b;
      OP_NOR:  res_c = ~(opnd_a | opnd_b);
      OP_SLL:  res_c = opnd_b << shamt;
      OP_SRL:  res_c = opnd_b >> shamt;
      OP_SRA:  res_c = $unsigned($signed(opnd_b) >>> shamt);
      OP_SLT:  res_c = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU: res_c = {{(WIDTH-1){1'b0}}, lt_u};
      default: res_c = '0;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [WIDTH-1:0] res_q;
      logic             zero_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_q  <= '0;
          zero_q <= 1'b1;
        end else begin
          res_q  <= res_c;
          zero_q <= (res_c == '0);
        end
      end
      assign result    = res_q;
      assign zero_flag = zero_q;
    end else begin : g_comb
      assign result    = res_c;
      assign zero_flag = (res_c == '0);
    end
  endgenerate

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int WIDTH = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int SHW = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [SHW-1:0]   shamt,
  input logic [WIDTH-1:0] result,
  input logic             zero_flag
);

  logic [3:0]       op_d;
  logic [WIDTH-1:0] a_d, b_d;
  logic [SHW-1:0]   sh_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_d <= '0;
      a_d  <= '0;
      b_d  <= '0;
      sh_d <= '0;
    end else begin
      op_d <= op_sel;
      a_d  <= opnd_a;
      b_d  <= opnd_b;
      sh_d <= shamt;
    end
  end

  logic [3:0]       op_v;
  logic [WIDTH-1:0] a_v, b_v;
  logic [SHW-1:0]   sh_v;
  assign op_v = REG_OUT ? op_d : op_sel;
  assign a_v  = REG_OUT ? a_d  : opnd_a;
  assign b_v  = REG_OUT ? b_d  : opnd_b;
  assign sh_v = REG_OUT ? sh_d : shamt;

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag == (result == '0)); // R11
  AST_SUB_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_v == 4'h1) |-> (result + b_v == a_v)); // R2
  AST_NOR_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_v == 4'h5 && b_v == '0) |-> (result == ~a_v)); // R4
  AST_SHIFT_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_v == 4'h6 && sh_v == '0) |-> (result == b_v)); // R5
  AST_SRA_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_v == 4'h8) |-> (result[WIDTH-1] == b_v[WIDTH-1])); // R7
  AST_SLT_ONEBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_v == 4'h9 || op_v == 4'hA) |-> (result[WIDTH-1:1] == '0)); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op_v > 4'hA) |-> (result == '0)); // R10

endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
  .opnd_b(opnd_b), .shamt(shamt), .result(result), .zero_flag(zero_flag)
);

// File: tb/int_alu_test.sv
`timescale 1ns/1ps
module int_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op = 4'h0;
  logic [31:0] a = '0, b = '0;
  logic [4:0]  sh = '0;
  logic [31:0] res_r, res_c;
  logic        z_r, z_c;
  int total = 0, bad = 0;
  logic [31:0] prev_exp = '0;

  always #2.5 clk = ~clk;

  int_alu #(.WIDTH(32), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .op_sel(op), .opnd_a(a), .opnd_b(b),
    .shamt(sh), .result(res_r), .zero_flag(z_r));
  int_alu #(.WIDTH(32), .REG_OUT(1'b0)) uut_c (
    .clk(clk), .rst_n(rst_n), .op_sel(op), .opnd_a(a), .opnd_b(b),
    .shamt(sh), .result(res_c), .zero_flag(z_c));

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] x,
                                        input logic [31:0] y, input logic [4:0] s);
    logic [31:0] r;
    longint sx, sy;
    sx = x[31] ? longint'(x) - 64'sd4294967296 : longint'(x);
    sy = y[31] ? longint'(y) - 64'sd4294967296 : longint'(y);
    r = 0;
    case (o)
      4'h0: r = 32'(longint'(x) + longint'(y));
      4'h1: r = 32'(longint'(x) - longint'(y) + 64'sd4294967296);
      4'h2: for (int i = 0; i < 32; i++) r[i] = x[i] & y[i];
      4'h3: for (int i = 0; i < 32; i++) r[i] = x[i] | y[i];
      4'h4: for (int i = 0; i < 32; i++) r[i] = x[i] ^ y[i];
      4'h5: for (int i = 0; i < 32; i++) r[i] = !(x[i] | y[i]);
      4'h6: for (int i = 0; i < 32; i++) r[i] = (i >= int'(s)) ? y[i - int'(s)] : 1'b0;
      4'h7: for (int i = 0; i < 32; i++) r[i] = (i + int'(s) < 32) ? y[i + int'(s)] : 1'b0;
      4'h8: for (int i = 0; i < 32; i++) r[i] = (i + int'(s) < 32) ? y[i + int'(s)] : y[31];
      4'h9: r = (sx < sy) ? 32'd1 : 32'd0;
      4'hA: r = (longint'(x) < longint'(y)) ? 32'd1 : 32'd0;
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'h0: return "R1"; 4'h1: return "R2";
      4'h2, 4'h3, 4'h4: return "R3"; 4'h5: return "R4";
      4'h6: return "R5"; 4'h7: return "R6"; 4'h8: return "R7";
      4'h9: return "R8"; 4'hA: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] x,
                       input logic [31:0] y, input logic [4:0] s);
    logic [31:0] e;
    @(negedge clk);
    op = o; a = x; b = y; sh = s;
    e = model(o, x, y, s);
    #1;
    check(tag(o), res_c, e);
    check("R11", {31'd0, z_c}, {31'd0, e == 0});
    check("R12", res_r, prev_exp);
    @(posedge clk);
    #1;
    check(tag(o), res_r, e);
    check("R11", {31'd0, z_r}, {31'd0, e == 0});
    prev_exp = e;
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    op = 4'h3; a = 32'h1234; b = 32'h8;
    repeat (3) @(negedge clk);
    check("R12", res_r, 32'h0);
    check("R12", {31'd0, z_r}, 32'd1);
    rst_n = 1'b1;
    op = 4'h0; a = 0; b = 0;
    @(posedge clk); #1;
    apply(4'h0, 32'hFFFFFFFF, 32'h1, 0);
    apply(4'h0, 32'h7FFFFFFF, 32'h1, 0);
    apply(4'h1, 32'h5, 32'h5, 0);
    apply(4'h1, 32'h0, 32'h1, 0);
    apply(4'h1, 32'h80000000, 32'h1, 0);
    apply(4'h2, 32'h00000DC0, 32'h00003C00, 0);
    apply(4'h3, 32'h00000DC0, 32'h00003C00, 0);
    apply(4'h4, 32'hA5A5A5A5, 32'hFFFF0000, 0);
    apply(4'h5, 32'h00003C00, 32'h0, 0);
    apply(4'h5, 32'hFFFFFFFF, 32'h0, 0);
    apply(4'h6, 0, 32'h00000001, 31);
    apply(4'h6, 0, 32'hDEADBEEF, 0);
    apply(4'h6, 0, 32'hDEADBEEF, 4);
    apply(4'h7, 0, 32'h80000000, 31);
    apply(4'h7, 0, 32'hF0000000, 4);
    apply(4'h8, 0, 32'h80000000, 31);
    apply(4'h8, 0, 32'hF0000000, 4);
    apply(4'h8, 0, 32'h70000000, 4);
    apply(4'h9, 32'hFFFFFFFF, 32'h1, 0);
    apply(4'hA, 32'hFFFFFFFF, 32'h1, 0);
    apply(4'h9, 32'h80000000, 32'h7FFFFFFF, 0);
    apply(4'hA, 32'h80000000, 32'h7FFFFFFF, 0);
    apply(4'h9, 32'h5, 32'h5, 0);
    apply(4'hA, 32'h1, 32'h2, 0);
    for (int c = 11; c < 16; c++) apply(4'(c), 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd7);
    for (int n = 0; n < 600; n++)
      apply(4'($urandom % 16), $urandom, $urandom, 5'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule